// File: doc/BRIEF.md
# Bus Master Access Permission Filter

This block sits between the request side of a multi-master bus matrix and the slave ports. Each request carries a master ID, a target slave index and a direction. The filter maps the master ID onto one of four permission groups. It then looks up that group's read or write allow bit for the target slave. If the bit allows the request, it is forwarded. If not, the request is dropped and an error response is produced.

Four permission words hold the allow bits, one word per group. Every allow bit comes up set after reset, so all traffic passes until configuration restricts it. A configuration strobe loads each word once, and that word is then locked until the next reset. Software can read the words back but has no path to write them.

A blocked request raises a one-cycle error pulse. It also sets a sticky violation flag, which keeps the ID of the first master that was refused.

Top module: `bus_perm_filter`

## Requirements
- R1: After reset every permission word reads back 0x3FF on `rd_word`, `err_resp` and `viol_flag` are 0, and every request is forwarded.
- R2: Master IDs map to groups as follows: group 0 = {0,1,2}, group 1 = {4,5,FABRIC_MID} (default 12), group 2 = {3,6,7,8}, group 3 = {9}.
- R3: Each word has five read/write pairs. Slave 0 uses bits 1:0, slave 1 uses bits 3:2, slave 2 uses bits 5:4, slave 3 uses bits 7:6 and slave 6 uses bits 9:8. The even bit of a pair is read, the odd bit is write. Bits 31:10 of `rd_word` always read 0.
- R4: A request to a protected slave is forwarded only when its group's bit for that direction is 1. A cleared read bit blocks only reads, and a cleared write bit blocks only writes.
- R5: Requests are always forwarded when they target slave indexes 4, 5 or 7 to 15, or when they come from master IDs outside every group.
- R6: When a request is blocked, `fwd_valid` is 0 in that same cycle. `err_resp` is 1 in the following cycle only, once for each blocked request.
- R7: `viol_flag` is set in the cycle after the first blocked request, and `viol_mid` holds that request's master ID. Later violations change neither output. Only reset clears them.
- R8: Each word accepts exactly one load after reset. Later strobes to that word are ignored until the next reset.
- R9: A load with `cfg_load`=1 writes `cfg_data` into the word chosen by `cfg_group`. The new value is visible on `rd_word` from the next cycle.
- R10: When `req_valid` is 0, nothing is forwarded and no error response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_group | input | 2 | Group word selected for loading |
| cfg_data | input | 10 | Permission bits to load |
| rd_group | input | 2 | Group word selected for readback |
| rd_word | output | 32 | Read-only view of the selected word |
| req_valid | input | 1 | Request present |
| req_mid | input | 4 | Requesting master ID |
| req_slave | input | 4 | Target slave index |
| req_write | input | 1 | 1 = write, 0 = read |
| fwd_valid | output | 1 | Request passed to the slave |
| err_resp | output | 1 | One-cycle error response for a blocked request |
| viol_flag | output | 1 | Sticky violation indicator |
| viol_mid | output | 4 | Master ID of the first violation |

## Verification
The assertions take the request fields to be stable and meaningful only while `req_valid` is high. They also take the readback select to be a plain mux input, with no timing relationship to the requests. The stimulus changes all inputs half a cycle away from the sampling edge. It separates table requests with idle cycles, so each error pulse can be tied to exactly one request. The back-to-back and idle-after-block patterns are kept to directed tests.

// File: rtl/bus_perm_filter.sv
module bus_perm_filter #(
  parameter int MID_W      = 4,
  parameter int SLV_W      = 4,
  parameter int WORD_W     = 32,
  parameter int NGRP       = 4,
  parameter int NPROT      = 5,
  parameter int FABRIC_MID = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_load,
  input  logic [$clog2(NGRP)-1:0] cfg_group,
  input  logic [2*NPROT-1:0]      cfg_data,
  input  logic [$clog2(NGRP)-1:0] rd_group,
  output logic [WORD_W-1:0]       rd_word,
  input  logic                    req_valid,
  input  logic [MID_W-1:0]        req_mid,
  input  logic [SLV_W-1:0]        req_slave,
  input  logic                    req_write,
  output logic                    fwd_valid,
  output logic                    err_resp,
  output logic                    viol_flag,
  output logic [MID_W-1:0]        viol_mid
);
  localparam int PERM_W = 2 * NPROT;
  localparam int GRP_W  = $clog2(NGRP);
  localparam int SLOT_W = $clog2(NPROT);

  logic [PERM_W-1:0] perm_q [NGRP];
  logic [NGRP-1:0]   lock_q;

  genvar g;
  generate
    for (g = 0; g < NGRP; g++) begin : gen_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          perm_q[g] <= '1;
          lock_q[g] <= 1'b0;
        end else if (cfg_load && cfg_group == GRP_W'(g) && !lock_q[g]) begin
          perm_q[g] <= cfg_data;
          lock_q[g] <= 1'b1;
        end
      end

      AST_LOCKED_WORD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q[g] |=> $stable(perm_q[g])); // R8
    end
  endgenerate

  assign rd_word = WORD_W'(perm_q[rd_group]);

  logic             grp_hit;
  logic [GRP_W-1:0] grp_idx;
  always_comb begin
    grp_hit = 1'b1;
    grp_idx = '0;
    case (int'(req_mid))
      0, 1, 2:    grp_idx = GRP_W'(0);
      4, 5:       grp_idx = GRP_W'(1);
      3, 6, 7, 8: grp_idx = GRP_W'(2);
      9:          grp_idx = GRP_W'(3);
      default:    grp_hit = 1'b0;
    endcase
    if (req_mid == MID_W'(FABRIC_MID)) begin
      grp_hit = 1'b1;
      grp_idx = GRP_W'(1);
    end
  end

  logic              slot_hit;
  logic [SLOT_W-1:0] slot_idx;
  always_comb begin
    slot_hit = 1'b1;
    slot_idx = '0;
    case (int'(req_slave))
      0, 1, 2, 3: slot_idx = SLOT_W'(req_slave);
      6:          slot_idx = SLOT_W'(4);
      default:    slot_hit = 1'b0;
    endcase
  end

  logic [SLOT_W:0] bit_idx;
  logic            allow;
  logic            blocked;
  assign bit_idx   = {slot_idx, req_write};
  assign allow     = !(grp_hit && slot_hit) || perm_q[grp_idx][bit_idx];
  assign blocked   = req_valid && !allow;
  assign fwd_valid = req_valid && allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_resp  <= 1'b0;
      viol_flag <= 1'b0;
      viol_mid  <= '0;
    end else begin
      err_resp <= blocked;
      if (blocked && !viol_flag) begin
        viol_flag <= 1'b1;
        viol_mid  <= req_mid;
      end
    end
  end

  AST_ERR_AFTER_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !fwd_valid) |=> err_resp); // R6
  AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_resp |-> $past(req_valid && !fwd_valid)); // R6
  AST_IDLE_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !fwd_valid); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol_flag |=> (viol_flag && $stable(viol_mid))); // R7
  AST_UNPROT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (req_slave == SLV_W'(4) || req_slave == SLV_W'(5) || req_slave > SLV_W'(6)))
      |-> fwd_valid); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word[WORD_W-1:PERM_W] == '0); // R3
endmodule

// File: tb/bus_perm_filter_tb.sv
`timescale 1ns/1ps
module bus_perm_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [1:0]  cfg_group = '0;
  logic [9:0]  cfg_data = '0;
  logic [1:0]  rd_group = '0;
  logic [31:0] rd_word;
  logic        req_valid = 1'b0;
  logic [3:0]  req_mid = '0;
  logic [3:0]  req_slave = '0;
  logic        req_write = 1'b0;
  logic        fwd_valid, err_resp, viol_flag;
  logic [3:0]  viol_mid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bus_perm_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_group(cfg_group),
    .cfg_data(cfg_data), .rd_group(rd_group), .rd_word(rd_word),
    .req_valid(req_valid), .req_mid(req_mid), .req_slave(req_slave),
    .req_write(req_write), .fwd_valid(fwd_valid), .err_resp(err_resp),
    .viol_flag(viol_flag), .viol_mid(viol_mid)
  );

  // {mid[3:0], slave[3:0], write, expected forward}
  localparam logic [9:0] VEC [17] = '{
    {4'd0,  4'd0, 1'b0, 1'b0}, {4'd1,  4'd0, 1'b1, 1'b1},
    {4'd2,  4'd1, 1'b0, 1'b1}, {4'd4,  4'd1, 1'b1, 1'b0},
    {4'd12, 4'd1, 1'b1, 1'b0}, {4'd5,  4'd1, 1'b0, 1'b1},
    {4'd3,  4'd6, 1'b0, 1'b0}, {4'd8,  4'd6, 1'b1, 1'b0},
    {4'd7,  4'd3, 1'b1, 1'b1}, {4'd9,  4'd2, 1'b0, 1'b0},
    {4'd9,  4'd2, 1'b1, 1'b0}, {4'd9,  4'd3, 1'b0, 1'b1},
    {4'd0,  4'd4, 1'b0, 1'b1}, {4'd8,  4'd7, 1'b1, 1'b1},
    {4'd10, 4'd0, 1'b0, 1'b1}, {4'd15, 4'd6, 1'b1, 1'b1},
    {4'd3,  4'd5, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] g, input logic [9:0] d);
    @(negedge clk);
    cfg_load = 1'b1; cfg_group = g; cfg_data = d;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic readback(input string tag, input logic [1:0] g, input logic [31:0] exp);
    rd_group = g;
    #1;
    chk(tag, rd_word, exp);
  endtask

  task automatic request(input string tag, input logic [3:0] m, input logic [3:0] s,
                         input logic w, input logic exp_fwd);
    @(negedge clk);
    req_valid = 1'b1; req_mid = m; req_slave = s; req_write = w;
    #1;
    chk({tag, " fwd"}, 32'(fwd_valid), 32'(exp_fwd));
    @(negedge clk);
    chk({tag, " err"}, 32'(err_resp), 32'(!exp_fwd));
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int g = 0; g < 4; g++) readback("R1 reset word", 2'(g), 32'h3FF);
    chk("R1 err after reset", 32'(err_resp), 32'd0);
    chk("R1 flag after reset", 32'(viol_flag), 32'd0);
    request("R1 default allow", 4'd0, 4'd0, 1'b0, 1'b1);
    request("R1 default allow wr", 4'd9, 4'd6, 1'b1, 1'b1);

    // R9 loads, R3 layout
    load(2'd0, 10'h3FE);
    readback("R9 group0 word", 2'd0, 32'h3FE);
    load(2'd1, 10'h3F7);
    readback("R9 group1 word", 2'd1, 32'h3F7);
    load(2'd2, 10'h0FF);
    readback("R3 group2 word upper zero", 2'd2, 32'h0FF);
    load(2'd3, 10'h3CF);
    readback("R9 group3 word", 2'd3, 32'h3CF);

    // R2 R4 R5 R6 table
    for (int i = 0; i < 17; i++)
      request($sformatf("R2 R4 R5 vec%0d", i), VEC[i][9:6], VEC[i][5:2], VEC[i][1], VEC[i][0]);

    // R7 first violator kept
    chk("R7 flag", 32'(viol_flag), 32'd1);
    chk("R7 first mid", 32'(viol_mid), 32'd0);

    // R8 second load ignored
    load(2'd0, 10'h000);
    readback("R8 locked word", 2'd0, 32'h3FE);
    request("R8 lock keeps allow", 4'd1, 4'd0, 1'b1, 1'b1);

    // R10 idle with blocking pattern
    @(negedge clk);
    req_valid = 1'b0; req_mid = 4'd0; req_slave = 4'd0; req_write = 1'b0;
    #1;
    chk("R10 idle fwd", 32'(fwd_valid), 32'd0);
    @(negedge clk);
    chk("R10 idle err", 32'(err_resp), 32'd0);

    // R6 back-to-back blocked then allowed
    @(negedge clk);
    req_valid = 1'b1; req_mid = 4'd4; req_slave = 4'd1; req_write = 1'b1;
    @(negedge clk);
    chk("R6 b2b first err", 32'(err_resp), 32'd1);
    req_mid = 4'd9; req_slave = 4'd2; req_write = 1'b0;
    @(negedge clk);
    chk("R6 b2b second err", 32'(err_resp), 32'd1);
    req_mid = 4'd9; req_slave = 4'd3;
    @(negedge clk);
    chk("R6 err drops after allowed", 32'(err_resp), 32'd0);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R6 err stays low", 32'(err_resp), 32'd0);
    chk("R7 mid unchanged", 32'(viol_mid), 32'd0);

    // reset mid-run: R7 clear, R1 words restored, R8 lock released
    rst_n = 1'b0;
    #1;
    chk("R7 flag cleared by reset", 32'(viol_flag), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    readback("R1 word after rerun reset", 2'd0, 32'h3FF);
    load(2'd0, 10'h000);
    readback("R8 load after reset", 2'd0, 32'h000);
    request("R4 write block group0", 4'd2, 4'd3, 1'b1, 1'b0);
    chk("R7 new first mid", 32'(viol_mid), 32'd2);

    finish_run();
  end
endmodule